// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out, in hardware, the steps a small 32-bit core takes when it accepts an interrupt. A priority resolver hands it a request together with the index of the winning device interrupt. The block turns that index into an exception number by adding 16. It then waits until the instruction now executing has retired. Next it saves eight context words on the stack that the interrupted code was using, through a word-write memory port with a ready handshake.

Once the frame is written, the block loads the link register with the return token 0xFFFFFFF9 and writes the exception number into the status field. It publishes the lowered stack pointer and notes which pointer it belonged to. Handler code always runs on the main stack pointer. Last, it reads the handler address from a vector table through a one-word read port, loads it into the program counter output and pulses `done`.

Instruction execution, priority resolution and the unstacking on return all sit outside this block.

Top module: `exc_entry_seq`

## Requirements
- R1: A request is taken only while the block is idle, and the exception number recorded for it is the interrupt index plus 16.
- R2: After a request is taken, no memory write is issued before the cycle that follows the first cycle in which `instr_done` is high.
- R3: The frame is eight writes, and each write is held until the cycle in which `wr_ready` is high. Write k (k = 0..7) carries context word 7-k, where word 0 = r0, 1 = r1, 2 = r2, 3 = r3, 4 = r12, 5 = lr, 6 = pc and 7 = xpsr. It goes to base − 4·(k+1), so xpsr lands at base − 4 and r0 at base − 32.
- R4: The base is `psp_in` when `thread_on_psp` is 1 and `msp_in` otherwise, both sampled with `instr_done`. After entry, `sp_out` equals base − 32 and `sp_out_psp` shows which pointer was used.
- R5: After entry `lr_out` holds 0xFFFFFFF9.
- R6: After entry `status_exc` holds the exception number of the entry just taken.
- R7: The vector read is issued at VEC_BASE + 4·(exception number) and held until `rd_ready`. `pc_out` then takes the `rd_data` of that cycle.
- R8: `busy` is high from the cycle after a request is taken up to and including the single cycle in which `done` is high, and `pc_out` is already valid in that cycle.
- R9: After reset the block is idle, with `busy`, `done`, `wr_valid`, `rd_valid`, `pc_out`, `lr_out`, `status_exc` and `sp_out` all zero.
- R10: A request that arrives while `busy` is high has no effect on the exception number, vector address or status of the entry in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Interrupt request from the priority resolver |
| req_irq | input | IRQ_W | Index of the winning device interrupt |
| instr_done | input | 1 | Current instruction has retired |
| ctx_regs | input | 8x32 | Context words: r0, r1, r2, r3, r12, lr, pc, xpsr (index 0..7) |
| msp_in | input | 32 | Main stack pointer |
| psp_in | input | 32 | Process stack pointer |
| thread_on_psp | input | 1 | Interrupted code runs on the process stack |
| wr_valid | output | 1 | Stack write request |
| wr_addr | output | 32 | Stack write address |
| wr_data | output | 32 | Stack write data |
| wr_ready | input | 1 | Memory accepts the write |
| rd_valid | output | 1 | Vector read request |
| rd_addr | output | 32 | Vector read address |
| rd_ready | input | 1 | Read data valid and accepted |
| rd_data | input | 32 | Vector read data |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | One-cycle pulse when the program counter is loaded |
| pc_out | output | 32 | Handler start address |
| lr_out | output | 32 | Link register value for the handler |
| status_exc | output | IRQ_W+1 | Active exception number field |
| sp_out | output | 32 | Stack pointer after the frame push |
| sp_out_psp | output | 1 | The frame went onto the process stack |

## Verification
The hardest states to reach are a second request arriving while the block waits for the instruction to retire, and a push or vector read that is stalled for several cycles. Only deliberate timing of `req_valid`, `instr_done` and the two ready inputs produces them. The bench runs each entry with its own wait length, fires a stray request with a different index in the middle of that wait, and applies a write-stall rhythm and a read delay that change per scenario. A behavioural model, compared on every clock, then shows that the stray index never leaks into the address, the status field or the vector read.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int          FRAME_WORDS = 8;
    localparam int          IDX_W       = $clog2(FRAME_WORDS);
    localparam int          EXT_OFFSET  = 16;
    localparam logic [31:0] RET_TOKEN   = 32'hFFFF_FFF9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_PUSH,
        ST_SETUP,
        ST_FETCH,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic [31:0] sp;
        logic        on_psp;
    } frame_base_t;

    function automatic logic [31:0] vec_addr(input logic [31:0] base, input logic [31:0] exc);
        return base + (exc << 2);
    endfunction

    function automatic logic [31:0] slot_addr(input logic [31:0] sp, input logic [IDX_W-1:0] k);
        return sp - ((32'(k) + 32'd1) << 2);
    endfunction

endpackage

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
    import exc_entry_pkg::*;
#(
    parameter int IRQ_W = 5,
    localparam int EXC_W = IRQ_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [IRQ_W-1:0] req_irq,
    input  logic             instr_done,
    input  logic             wr_ready,
    input  logic             rd_ready,
    output seq_state_t       state,
    output logic [IDX_W-1:0] idx,
    output logic [EXC_W-1:0] exc_num,
    output logic             capture,
    output logic             setup,
    output logic             rd_take
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            idx     <= '0;
            exc_num <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    exc_num <= EXC_W'(req_irq) + EXC_W'(EXT_OFFSET);
                    state   <= ST_WAIT;
                end
                ST_WAIT: if (instr_done) begin
                    idx   <= '0;
                    state <= ST_PUSH;
                end
                ST_PUSH: if (wr_ready) begin
                    if (idx == IDX_W'(FRAME_WORDS - 1)) state <= ST_SETUP;
                    else                                idx   <= idx + 1'b1;
                end
                ST_SETUP: state <= ST_FETCH;
                ST_FETCH: if (rd_ready) state <= ST_DONE;
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        capture = (state == ST_WAIT) && instr_done;
        setup   = (state == ST_SETUP);
        rd_take = (state == ST_FETCH) && rd_ready;
    end

endmodule

// File: rtl/exc_frame_mux.sv
module exc_frame_mux
    import exc_entry_pkg::*;
(
    input  logic [FRAME_WORDS-1:0][31:0] ctx_q,
    input  frame_base_t                  base_q,
    input  logic [IDX_W-1:0]             idx,
    output logic [31:0]                  addr,
    output logic [31:0]                  data
);

    logic [IDX_W-1:0] word_sel;

    always_comb begin
        word_sel = IDX_W'(FRAME_WORDS - 1) - idx;
        data     = ctx_q[word_sel];
        addr     = slot_addr(base_q.sp, idx);
    end

endmodule

// File: rtl/exc_commit_regs.sv
module exc_commit_regs
    import exc_entry_pkg::*;
#(
    parameter int EXC_W = 6
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         capture,
    input  logic                         setup,
    input  logic                         rd_take,
    input  logic [FRAME_WORDS-1:0][31:0] ctx_regs,
    input  logic [31:0]                  msp_in,
    input  logic [31:0]                  psp_in,
    input  logic                         thread_on_psp,
    input  logic [EXC_W-1:0]             exc_num,
    input  logic [31:0]                  rd_data,
    output logic [FRAME_WORDS-1:0][31:0] ctx_q,
    output frame_base_t                  base_q,
    output logic [31:0]                  pc_out,
    output logic [31:0]                  lr_out,
    output logic [EXC_W-1:0]             status_exc,
    output logic [31:0]                  sp_out,
    output logic                         sp_out_psp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q      <= '0;
            base_q     <= '0;
            pc_out     <= '0;
            lr_out     <= '0;
            status_exc <= '0;
            sp_out     <= '0;
            sp_out_psp <= 1'b0;
        end else begin
            if (capture) begin
                ctx_q         <= ctx_regs;
                base_q.on_psp <= thread_on_psp;
                base_q.sp     <= thread_on_psp ? psp_in : msp_in;
            end
            if (setup) begin
                lr_out     <= RET_TOKEN;
                status_exc <= exc_num;
                sp_out     <= base_q.sp - 32'(FRAME_WORDS * 4);
                sp_out_psp <= base_q.on_psp;
            end
            if (rd_take) pc_out <= rd_data;
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int          IRQ_W    = 5,
    parameter logic [31:0] VEC_BASE = 32'h0000_0100,
    localparam int         EXC_W    = IRQ_W + 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    input  logic [IRQ_W-1:0]             req_irq,
    input  logic                         instr_done,
    input  logic [FRAME_WORDS-1:0][31:0] ctx_regs,
    input  logic [31:0]                  msp_in,
    input  logic [31:0]                  psp_in,
    input  logic                         thread_on_psp,
    output logic                         wr_valid,
    output logic [31:0]                  wr_addr,
    output logic [31:0]                  wr_data,
    input  logic                         wr_ready,
    output logic                         rd_valid,
    output logic [31:0]                  rd_addr,
    input  logic                         rd_ready,
    input  logic [31:0]                  rd_data,
    output logic                         busy,
    output logic                         done,
    output logic [31:0]                  pc_out,
    output logic [31:0]                  lr_out,
    output logic [EXC_W-1:0]             status_exc,
    output logic [31:0]                  sp_out,
    output logic                         sp_out_psp
);

    seq_state_t                   state;
    logic [IDX_W-1:0]             idx;
    logic [EXC_W-1:0]             exc_num;
    logic                         capture, setup, rd_take;
    logic [FRAME_WORDS-1:0][31:0] ctx_q;
    frame_base_t                  base_q;

    exc_seq_ctrl #(.IRQ_W(IRQ_W)) u_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_irq(req_irq),
        .instr_done(instr_done), .wr_ready(wr_ready), .rd_ready(rd_ready),
        .state(state), .idx(idx), .exc_num(exc_num),
        .capture(capture), .setup(setup), .rd_take(rd_take)
    );

    exc_commit_regs #(.EXC_W(EXC_W)) u_regs (
        .clk(clk), .rst(rst), .capture(capture), .setup(setup), .rd_take(rd_take),
        .ctx_regs(ctx_regs), .msp_in(msp_in), .psp_in(psp_in),
        .thread_on_psp(thread_on_psp), .exc_num(exc_num), .rd_data(rd_data),
        .ctx_q(ctx_q), .base_q(base_q), .pc_out(pc_out), .lr_out(lr_out),
        .status_exc(status_exc), .sp_out(sp_out), .sp_out_psp(sp_out_psp)
    );

    exc_frame_mux u_mux (
        .ctx_q(ctx_q), .base_q(base_q), .idx(idx),
        .addr(wr_addr), .data(wr_data)
    );

    always_comb begin
        wr_valid = (state == ST_PUSH);
        rd_valid = (state == ST_FETCH);
        rd_addr  = vec_addr(VEC_BASE, 32'(exc_num));
        busy     = (state != ST_IDLE);
        done     = (state == ST_DONE);
    end

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
    parameter int EXC_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_valid,
    input logic             wr_ready,
    input logic [31:0]      wr_addr,
    input logic [31:0]      wr_data,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic [31:0]      rd_addr,
    input logic             busy,
    input logic             done,
    input logic [31:0]      lr_out,
    input logic [EXC_W-1:0] status_exc
);

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R3

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R7

    AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(wr_valid && rd_valid)); // R3

    AST_NO_EARLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !wr_valid); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy); // R8

    AST_DONE_TOKEN: assert property (@(posedge clk) disable iff (rst)
        done |-> (lr_out == 32'hFFFF_FFF9)); // R5

    AST_EXC_OFFSET: assert property (@(posedge clk) disable iff (rst)
        done |-> (status_exc >= EXC_W'(16))); // R6

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.EXC_W(EXC_W)) u_chk (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_addr(rd_addr), .busy(busy), .done(done),
    .lr_out(lr_out), .status_exc(status_exc)
);

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;
    localparam int          IRQ_W = 5;
    localparam int          EXC_W = IRQ_W + 1;
    localparam logic [31:0] VBASE = 32'h0000_0100;

    logic clk = 0, rst = 1;
    logic req_valid = 0, instr_done = 0, thread_on_psp = 0;
    logic wr_ready = 0, rd_ready = 0;
    logic [IRQ_W-1:0] req_irq = '0;
    logic [7:0][31:0] ctx_regs = '0;
    logic [31:0] msp_in = 0, psp_in = 0, rd_data = 0;
    logic wr_valid, rd_valid, busy, done, sp_out_psp;
    logic [31:0] wr_addr, wr_data, rd_addr, pc_out, lr_out, sp_out;
    logic [EXC_W-1:0] status_exc;

    always #4 clk = ~clk;

    exc_entry_seq #(.IRQ_W(IRQ_W), .VEC_BASE(VBASE)) u0 (.*);

    int tests = 0, fails = 0, cyc = 0, wr_stall = 0, rd_delay = 0, rd_wait = 0;
    bit chk_on = 0, finished = 0;

    // behavioural reference
    int m_ph = 0, m_k = 0, m_exc = 0;
    logic [31:0] m_sp = 0, m_pc = 0, m_lr = 0, m_spo = 0;
    int m_stat = 0;
    bit m_psp = 0, m_spop = 0;
    logic [31:0] m_ctx [8];

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_k = 0; m_exc = 0; m_pc = 0; m_lr = 0; m_spo = 0;
            m_stat = 0; m_spop = 0; m_sp = 0; m_psp = 0;
        end else begin
            case (m_ph)
                0: if (req_valid) begin m_exc = int'(req_irq) + 16; m_ph = 1; end
                1: if (instr_done) begin
                    m_ph = 2; m_k = 0; m_psp = thread_on_psp;
                    m_sp = thread_on_psp ? psp_in : msp_in;
                    for (int i = 0; i < 8; i++) m_ctx[i] = ctx_regs[i];
                end
                2: if (wr_ready) begin if (m_k == 7) m_ph = 3; else m_k++; end
                3: begin m_lr = 32'hFFFF_FFF9; m_stat = m_exc; m_spo = m_sp - 32; m_spop = m_psp; m_ph = 4; end
                4: if (rd_ready) begin m_pc = rd_data; m_ph = 5; end
                default: m_ph = 0;
            endcase
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (chk_on) begin
            chk("R8 busy", 32'(busy), 32'(m_ph != 0));
            chk("R8 done", 32'(done), 32'(m_ph == 5));
            chk("R2/R3 wr_valid", 32'(wr_valid), 32'(m_ph == 2));
            if (m_ph == 2) begin
                chk("R3/R4 wr_addr", wr_addr, m_sp - 32'((m_k + 1) * 4));
                chk("R3 wr_data", wr_data, m_ctx[7 - m_k]);
            end
            chk("R7 rd_valid", 32'(rd_valid), 32'(m_ph == 4));
            if (m_ph == 4) chk("R7/R1/R10 rd_addr", rd_addr, VBASE + 32'(4 * m_exc));
            chk("R7 pc_out", pc_out, m_pc);
            chk("R5 lr_out", lr_out, m_lr);
            chk("R6/R1/R10 status_exc", 32'(status_exc), 32'(m_stat));
            chk("R4 sp_out", sp_out, m_spo);
            chk("R4 sp_out_psp", 32'(sp_out_psp), 32'(m_spop));
        end
    end

    task automatic tick();
        @(negedge clk); #1;
        wr_ready = (wr_stall == 0) ? 1'b1 : ((cyc % (wr_stall + 1)) == 0);
        if (rd_valid) begin rd_ready = (rd_wait >= rd_delay); rd_wait++; end
        else begin rd_ready = 0; rd_wait = 0; end
    endtask

    task automatic entry(int irq, bit psp, logic [31:0] msp, logic [31:0] pspv,
                         int wait_n, int stall, int rdel, logic [31:0] vec, int stray);
        wr_stall = stall; rd_delay = rdel; rd_data = vec;
        thread_on_psp = psp; msp_in = msp; psp_in = pspv;
        for (int i = 0; i < 8; i++) ctx_regs[i] = 32'hC000_0000 + 32'(irq << 8) + 32'(i);
        req_valid = 1; req_irq = IRQ_W'(irq);
        tick();
        req_valid = 0;
        for (int i = 0; i < wait_n; i++) begin
            if (i == 0 && stray >= 0) begin req_valid = 1; req_irq = IRQ_W'(stray); end   // R10 stray
            else req_valid = 0;
            tick();
        end
        req_valid = 0; instr_done = 1;
        tick();
        instr_done = 0;
        for (int i = 0; i < 200 && !done; i++) tick();
        // R8 done seen, pc valid at that cycle
        chk("R8 done reached", 32'(done), 32'd1);
        if (done) chk("R7 pc at done", pc_out, vec);
        tick(); tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0; chk_on = 1;
        @(negedge clk); #1;
        chk("R9 reset busy", 32'(busy), 0);
        chk("R9 reset wr_valid", 32'(wr_valid), 0);
        chk("R9 reset rd_valid", 32'(rd_valid), 0);
        chk("R9 reset lr/pc", lr_out | pc_out | sp_out, 0);
        chk("R9 reset status", 32'(status_exc), 0);
        entry(0,  0, 32'h2000_1000, 32'h2000_8000, 0, 0, 0, 32'h0000_4001, -1);
        entry(31, 1, 32'h2000_1000, 32'h2000_8000, 3, 2, 3, 32'h0000_5551, 7);
        entry(5,  0, 32'h2000_0FE0, 32'h1111_0000, 5, 1, 1, 32'h0000_6001, 12);
        entry(17, 1, 32'h0000_0000, 32'h0000_0020, 2, 3, 0, 32'hFFFF_FFFD, 0);
        chk("R4 psp path sp", sp_out, 32'h0000_0000);
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1; tests++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule